// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is the frame engine and register front end of an SPI master. Software queues 32-bit command words into a small transmit FIFO. Each word carries up to 16 bits of frame data and the control for that one frame: which chip-select lines to drive, whether to keep them driven after the frame, which stored format set to use, whether the frame ends a queue, and whether the frame counter restarts. Each format set holds the frame length (4 to 16 bits), clock polarity, clock phase and bit order.

Frames are shifted out one after another as long as commands are waiting. Each word received from the slave goes into a receive FIFO, which software drains by reading a pop register. A frame marked as the end of a queue raises a sticky status flag and, if enabled, an interrupt. No further commands are consumed until software clears that flag. The serial clock rate is set outside the block: an external strobe, `half_tick`, marks each half period of SCK.

Top module: `cq_spi_master`

## Requirements
- R1: After reset, `sck`, `irq` and `mosi` are 0, `cs` equals 6'h3F, and reads return 0x003F0000 from the control register (offset 0x00), 0 from the status register (0x2C) and 0 from the counter register (0x08).
- R2: A format set at offset 0x0C + 4·k stores the frame length minus one in bits 30:27 (values below 3 act as 3). A pushed word (offset 0x34) selects set k with bits 30:28. The frame sends the low N bits of data bits 15:0 and ignores the higher data bits.
- R3: Bit 24 of the format set sends and assembles the frame least-significant bit first. When it is clear, the most-significant bit goes first.
- R4: Format bits 26 (CPOL) and 25 (CPHA) set the SCK idle level and the sampling edge. With CPHA 0 both sides sample on the leading edge; with CPHA 1 they sample on the trailing edge. Between frames, SCK holds the idle level of the most recently started frame.
- R5: Reading offset 0x38 returns the oldest received frame in bits 15:0 and removes it from the FIFO. Reading it when the FIFO is empty returns 0.
- R6: During a frame, every line set in pushed bits 21:16 drives the inverse of its idle level. The idle levels are control bits 21:16. Lines whose pushed bit 31 is set stay driven until the next frame starts; otherwise they return to their idle level once the frame ends.
- R7: When a frame with pushed bit 27 completes, status bit 28 is set. Writing 1 to that bit clears it. `irq` is high exactly while the flag is set and interrupt-enable bit 28 (offset 0x30) is set.
- R8: While status bit 28 is set, no further command is taken from the transmit FIFO.
- R9: Bits 31:16 of offset 0x08 count the frames started. A frame whose pushed bit 26 is set restarts the count, so that frame reads as 1.
- R10: A frame that completes while the 4-entry receive FIFO is full is dropped, and status bit 27 is set. Writing 1 to status bit 27 clears it.
- R11: Writing control bit 11 empties the transmit FIFO, and writing control bit 10 empties the receive FIFO. Both bits read back as 0.
- R12: Commands are taken only while control bit 31 is set. Queued commands wait while it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data returns on the following cycle |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| half_tick | input | 1 | One-cycle strobe marking each SCK half period |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs | output | 6 | Chip-select lines |
| irq | output | 1 | End-of-queue interrupt |

## Verification
The bench builds the block with its defaults: two format sets and FIFOs four entries deep. With a depth of four, a single five-frame queue is enough to fill the receive FIFO and reach the overflow drop. With two format sets, a later queue can use a very different format (12-bit, inverted clock, late sampling, LSB-first) without rewriting the first set. A behavioural slave in the bench decodes the bus on every SCK edge from the configured mode alone. Its view of each frame is compared with the words pushed and with the words popped.

// File: rtl/cq_spi_pkg.sv
package cq_spi_pkg;

  localparam int CS_LINES = 6;
  localparam int DATA_W   = 16;

  // Layout of a pushed command word (bit 31 down to bit 0)
  typedef struct packed {
    logic                keep_cs;   // 31
    logic [2:0]          fmt_sel;   // 30:28
    logic                last;      // 27
    logic                cnt_restart; // 26
    logic [3:0]          spare;     // 25:22
    logic [CS_LINES-1:0] cs_sel;    // 21:16
    logic [DATA_W-1:0]   data;      // 15:0
  } push_cmd_t;

  // Stored frame format (register bits 30:24)
  typedef struct packed {
    logic [3:0] len_m1;
    logic       cpol;
    logic       cpha;
    logic       lsb_first;
  } frame_fmt_t;

endpackage

// File: rtl/cq_spi_fifo.sv
module cq_spi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [PW:0]      count;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (count == (PW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !flush |=> full); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push && !flush |=> empty); // R5

endmodule

// File: rtl/cq_spi_frame_engine.sv
module cq_spi_frame_engine
  import cq_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  frame_fmt_t        fmt,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              half_tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);
  frame_fmt_t        fmt_q;
  logic [DATA_W-1:0] txd_q, rxd_q;
  logic [4:0]        edge_q;
  logic              busy_q, done_q, sck_q, mosi_q;

  function automatic logic pick(input logic [DATA_W-1:0] d, input logic [3:0] idx,
                                input logic [3:0] n_m1, input logic lsb);
    return lsb ? d[idx] : d[n_m1 - idx];
  endfunction

  logic [3:0] start_len;
  assign start_len = (fmt.len_m1 < 4'd3) ? 4'd3 : fmt.len_m1;

  logic       is_sample, is_last;
  logic [3:0] rx_idx, tx_idx, rx_pos;
  logic [4:0] edge_inc;
  assign edge_inc  = edge_q + 5'd1;
  assign is_sample = (edge_q[0] == fmt_q.cpha);
  assign is_last   = (edge_q == {fmt_q.len_m1, 1'b1});
  assign rx_idx    = edge_q[4:1];
  assign tx_idx    = fmt_q.cpha ? edge_q[4:1] : edge_inc[4:1];
  assign rx_pos    = fmt_q.lsb_first ? rx_idx : fmt_q.len_m1 - rx_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      edge_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          fmt_q  <= '{len_m1: start_len, cpol: fmt.cpol, cpha: fmt.cpha,
                      lsb_first: fmt.lsb_first};
          txd_q  <= tx_data;
          rxd_q  <= '0;
          edge_q <= '0;
          sck_q  <= fmt.cpol;
          mosi_q <= pick(tx_data, 4'd0, start_len, fmt.lsb_first);
        end
      end else if (half_tick) begin
        sck_q <= ~sck_q;
        if (is_sample)
          rxd_q[rx_pos] <= miso;
        else if (!is_last)
          mosi_q <= pick(txd_q, tx_idx, fmt_q.len_m1, fmt_q.lsb_first);
        if (is_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          edge_q <= edge_inc;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign rx_data = rxd_q;

  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start |=> $stable(sck_q)); // R4
  AST_SCK_HOME: assert property (@(posedge clk) disable iff (rst)
    done_q |-> sck_q == fmt_q.cpol); // R4

endmodule

// File: rtl/cq_spi_master.sv
module cq_spi_master
  import cq_spi_pkg::*;
#(
  parameter int ATTR_SETS  = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                half_tick,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic [CS_LINES-1:0] cs,
  output logic                irq
);
  localparam int SEL_W = (ATTR_SETS > 1) ? $clog2(ATTR_SETS) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_FMT0 = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_PUSH = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(8'h38);

  // ---- configuration and status state ----
  logic                run_en, ien_q, last_flag, ovf_flag;
  logic [CS_LINES-1:0] idle_lvl, cs_drive;
  logic [15:0]         frame_cnt;
  logic                cur_keep, cur_last;
  logic [31:0]         rdata_q;
  logic                irq_q;
  frame_fmt_t          fmt_q [ATTR_SETS];

  logic wr_ctrl, wr_stat, tx_flush, rx_flush;
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign tx_flush = wr_ctrl && reg_wdata[11];
  assign rx_flush = wr_ctrl && reg_wdata[10];

  // ---- FIFOs ----
  logic [31:0]       tx_head;
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] rx_head, eng_rx;
  logic              rx_full, rx_empty, rx_pop;
  logic              eng_busy, eng_done, start;

  cq_spi_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(reg_wr && (reg_addr == A_PUSH)), .din(reg_wdata),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty));

  cq_spi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_done && !rx_full), .din(eng_rx),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty));

  // ---- frame launch ----
  push_cmd_t  cmd;
  frame_fmt_t sel_fmt;
  assign cmd     = push_cmd_t'(tx_head);
  assign sel_fmt = fmt_q[cmd.fmt_sel[SEL_W-1:0]];
  assign start   = run_en && !eng_busy && !eng_done && !last_flag && !tx_empty && !tx_flush;
  assign tx_pop  = start;
  assign rx_pop  = reg_rd && (reg_addr == A_POP) && !rx_empty;

  cq_spi_frame_engine u_engine (
    .clk(clk), .rst(rst), .start(start), .fmt(sel_fmt), .tx_data(cmd.data),
    .half_tick(half_tick), .miso(miso), .busy(eng_busy), .done(eng_done),
    .sck(sck), .mosi(mosi), .rx_data(eng_rx));

  // ---- format sets ----
  for (genvar g = 0; g < ATTR_SETS; g++) begin : g_fmt
    always_ff @(posedge clk) begin
      if (rst)
        fmt_q[g] <= '0;
      else if (reg_wr && (reg_addr == ADDR_W'(A_FMT0 + 4 * g)))
        fmt_q[g] <= frame_fmt_t'(reg_wdata[30:24]);
    end
  end

  // ---- control, status and frame bookkeeping ----
  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      idle_lvl  <= '1;
      ien_q     <= 1'b0;
      last_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      cs_drive  <= '0;
      frame_cnt <= '0;
      cur_keep  <= 1'b0;
      cur_last  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_en   <= reg_wdata[31];
        idle_lvl <= reg_wdata[21:16];
      end
      if (reg_wr && (reg_addr == A_IEN)) ien_q <= reg_wdata[28];
      if (wr_stat && reg_wdata[28]) last_flag <= 1'b0;
      if (wr_stat && reg_wdata[27]) ovf_flag  <= 1'b0;
      if (start) begin
        cur_keep  <= cmd.keep_cs;
        cur_last  <= cmd.last;
        cs_drive  <= cmd.cs_sel;
        frame_cnt <= cmd.cnt_restart ? 16'd1 : frame_cnt + 16'd1;
      end
      if (eng_done) begin
        if (!cur_keep) cs_drive <= '0;
        if (cur_last)  last_flag <= 1'b1;
        if (rx_full)   ovf_flag  <= 1'b1;
      end
      irq_q <= last_flag && ien_q;
    end
  end

  // ---- register read ----
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: rd_mux = {run_en, 9'd0, idle_lvl, 16'd0};
      A_CNT:  rd_mux = {frame_cnt, 16'd0};
      A_STAT: rd_mux = {3'd0, last_flag, ovf_flag, 27'd0};
      A_IEN:  rd_mux = {3'd0, ien_q, 28'd0};
      A_POP:  rd_mux = rx_empty ? 32'd0 : {16'd0, rx_head};
      default: rd_mux = '0;
    endcase
    for (int k = 0; k < ATTR_SETS; k++)
      if (reg_addr == ADDR_W'(A_FMT0 + 4 * k))
        rd_mux = {1'b0, fmt_q[k], 24'd0};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign cs        = idle_lvl ^ cs_drive;
  assign irq       = irq_q;

  logic unused_bits;
  assign unused_bits = ^{cmd.spare, cmd.fmt_sel};

  AST_LAST_HALTS: assert property (@(posedge clk) disable iff (rst)
    last_flag && !eng_busy |=> !eng_busy); // R8
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    eng_done && !cur_keep |=> cs == idle_lvl); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(last_flag && ien_q)); // R7
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    eng_done && rx_full |=> ovf_flag); // R10
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> frame_cnt != 16'd0); // R9
  AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
    !run_en && !eng_busy |=> !eng_busy); // R12

endmodule

// File: tb/cq_spi_master_bench.sv
module cq_spi_master_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        half_tick = 1'b0, miso = 1'b0;
  logic        sck, mosi, irq;
  logic [5:0]  cs;

  cq_spi_master u_cq_spi_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_tick(half_tick),
    .miso(miso), .sck(sck), .mosi(mosi), .cs(cs), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // ---- behavioural slave ----
  int         cur_n = 8;
  bit         cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
  logic [5:0] idle_b = 6'h3F;
  logic [15:0] slv_tx[$];
  logic [15:0] slv_got[$];
  int          bidx = 0;
  logic [15:0] acc = '0;
  bit          cs_on_prev = 0;
  int          assert_evt[6];
  logic [5:0]  act_prev = '0;

  function automatic int bpos(input int i);
    return cur_lsb ? i : cur_n - 1 - i;
  endfunction

  task automatic drive_miso();
    logic [15:0] w;
    w = (slv_tx.size() > 0) ? slv_tx[0] : 16'h0;
    miso = w[bpos(bidx)];
  endtask

  always @(sck) begin
    if (!rst && cs_on_prev && ((cs ^ idle_b) != 0)) begin
      bit lead;
      lead = (sck != cur_cpol);
      if (lead != cur_cpha) begin
        acc[bpos(bidx)] = mosi;
        bidx++;
        if (bidx == cur_n) begin
          slv_got.push_back(acc);
          acc = '0;
          bidx = 0;
          if (slv_tx.size() > 0) void'(slv_tx.pop_front());
        end
        drive_miso();
      end
    end
  end

  always @(negedge clk) begin
    logic [5:0] act;
    act = cs ^ idle_b;
    cs_on_prev <= (act != 0);
    for (int i = 0; i < 6; i++)
      if (act[i] && !act_prev[i]) assert_evt[i]++;
    act_prev = act;
  end

  initial begin
    forever begin
      @(negedge clk);
      half_tick = ~half_tick;
    end
  end

  // ---- register access ----
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_last(input string tag);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h2C, s);
      if (s[28]) break;
    end
    chk(s[28] === 1'b1, {tag, " end-of-queue flag"}, {31'd0, s[28]}, 32'd1);
  endtask

  task automatic clear_evt();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) assert_evt[i] = 0;
  endtask

  logic [31:0] v;

  initial begin
    for (int i = 0; i < 6; i++) assert_evt[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cs === 6'h3F, "R1 cs", {26'd0, cs}, 32'h3F);
    chk(sck === 1'b0 && irq === 1'b0 && mosi === 1'b0, "R1 sck/irq/mosi",
        {29'd0, sck, irq, mosi}, 32'd0);
    rd(8'h00, v); chk(v === 32'h003F_0000, "R1 control", v, 32'h003F_0000);
    rd(8'h2C, v); chk(v === 32'h0, "R1 status", v, 32'h0);
    rd(8'h08, v); chk(v === 32'h0, "R1 counter", v, 32'h0);

    // R2 R3 R4 R6: two 8-bit frames, mode 0, MSB first, held chip select
    wr(8'h0C, 32'd7 << 27);
    wr(8'h00, 32'h803F_0000);
    cur_n = 8; cur_cpol = 0; cur_cpha = 0; cur_lsb = 0; idle_b = 6'h3F;
    slv_tx.push_back(16'hA5); slv_tx.push_back(16'h3C); drive_miso();
    clear_evt();
    wr(8'h34, (32'd1 << 31) | (32'd1 << 26) | (32'd1 << 16) | 32'h5A);
    wr(8'h34, (32'd1 << 27) | (32'd1 << 16) | 32'hC3);
    wait_last("R7 queue A");
    chk(slv_got.size() == 2 && slv_got[0] == 16'h5A, "R2 R3 R4 frame 1 mosi",
        {16'd0, slv_got[0]}, 32'h5A);
    chk(slv_got.size() == 2 && slv_got[1] == 16'hC3, "R2 R3 R4 frame 2 mosi",
        {16'd0, slv_got[1]}, 32'hC3);
    chk(assert_evt[0] == 1, "R6 held select asserts once", assert_evt[0], 1);
    chk(cs === 6'h3F, "R6 select released", {26'd0, cs}, 32'h3F);
    rd(8'h38, v); chk(v === 32'hA5, "R5 pop oldest", v, 32'hA5);
    rd(8'h38, v); chk(v === 32'h3C, "R5 pop second", v, 32'h3C);
    rd(8'h38, v); chk(v === 32'h0, "R5 pop empty", v, 32'h0);
    rd(8'h2C, v); chk(v === 32'h1000_0000, "R7 status flag", v, 32'h1000_0000);
    chk(irq === 1'b0, "R7 irq masked", {31'd0, irq}, 32'd0);
    rd(8'h08, v); chk(v === 32'h0002_0000, "R9 count two", v, 32'h0002_0000);

    // R8: halted while flag is set; second format set; line 2 idles low
    wr(8'h10, (32'd11 << 27) | (32'd1 << 26) | (32'd1 << 25) | (32'd1 << 24));
    wr(8'h00, 32'h803B_0000);
    idle_b = 6'h3B;
    repeat (2) @(negedge clk);
    chk(cs === 6'h3B, "R6 idle levels", {26'd0, cs}, 32'h3B);
    wr(8'h34, (32'd1 << 28) | (32'd1 << 27) | (32'd1 << 18) | 32'hFABC);
    repeat (300) @(negedge clk);
    chk(slv_got.size() == 2, "R8 no frame while flagged", slv_got.size(), 2);
    rd(8'h08, v); chk(v === 32'h0002_0000, "R8 counter frozen", v, 32'h0002_0000);
    wr(8'h30, 32'h1000_0000);
    repeat (2) @(negedge clk);
    chk(irq === 1'b1, "R7 irq raised", {31'd0, irq}, 32'd1);
    cur_n = 12; cur_cpol = 1; cur_cpha = 1; cur_lsb = 1;
    slv_tx.push_back(16'h5E7); drive_miso();
    clear_evt();
    wr(8'h2C, 32'h1000_0000);
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R7 irq cleared", {31'd0, irq}, 32'd0);
    wait_last("R8 resumed");
    chk(slv_got.size() == 3 && slv_got[2] == 16'hABC, "R2 R3 R4 12-bit lsb mode3",
        {16'd0, slv_got[2]}, 32'hABC);
    rd(8'h38, v); chk(v === 32'h5E7, "R3 R4 rx lsb mode3", v, 32'h5E7);
    rd(8'h08, v); chk(v === 32'h0003_0000, "R9 count three", v, 32'h0003_0000);
    chk(assert_evt[2] == 1 && cs === 6'h3B, "R6 line 2 active high once",
        {26'd0, cs}, 32'h3B);
    wr(8'h2C, 32'h1000_0000);
    wr(8'h30, 32'h0);

    // R10: 4-bit frames overflow the receive FIFO
    wr(8'h0C, (32'd3 << 27) | (32'd1 << 26));
    wr(8'h00, 32'h803F_0000);
    idle_b = 6'h3F;
    cur_n = 4; cur_cpol = 1; cur_cpha = 0; cur_lsb = 0;
    for (int i = 1; i <= 5; i++) slv_tx.push_back(16'(i));
    drive_miso();
    clear_evt();
    wr(8'h34, (32'd1 << 31) | (32'd1 << 26) | (32'd1 << 21) | 32'hFF9);
    wr(8'h34, (32'd1 << 31) | (32'd1 << 21) | 32'h6);
    wr(8'h34, (32'd1 << 31) | (32'd1 << 21) | 32'hF);
    wr(8'h34, (32'd1 << 31) | (32'd1 << 21) | 32'h0);
    wr(8'h34, (32'd1 << 27) | (32'd1 << 21) | 32'h3);
    wait_last("R10 queue");
    chk(slv_got.size() == 8 && slv_got[3] == 16'h9, "R2 high data bits ignored",
        {16'd0, slv_got[3]}, 32'h9);
    chk(slv_got.size() == 8 && slv_got[7] == 16'h3, "R2 4-bit last frame",
        {16'd0, slv_got[7]}, 32'h3);
    rd(8'h2C, v); chk(v === 32'h1800_0000, "R10 overflow flag", v, 32'h1800_0000);
    for (int i = 1; i <= 4; i++) begin
      rd(8'h38, v); chk(v === 32'(i), "R10 kept entry", v, 32'(i));
    end
    rd(8'h38, v); chk(v === 32'h0, "R10 fifth dropped", v, 32'h0);
    rd(8'h08, v); chk(v === 32'h0005_0000, "R9 restart count", v, 32'h0005_0000);
    wr(8'h2C, 32'h1800_0000);
    rd(8'h2C, v); chk(v === 32'h0, "R10 flags cleared", v, 32'h0);

    // R12: commands wait while disabled
    wr(8'h00, 32'h003F_0000);
    slv_tx.push_back(16'hA); drive_miso();
    wr(8'h34, (32'd1 << 27) | (32'd1 << 16) | 32'h5);
    repeat (300) @(negedge clk);
    chk(slv_got.size() == 8, "R12 no frame while disabled", slv_got.size(), 8);
    wr(8'h00, 32'h803F_0000);
    wait_last("R12 enabled");
    chk(slv_got.size() == 9 && slv_got[8] == 16'h5, "R12 frame after enable",
        {16'd0, slv_got[8]}, 32'h5);
    wr(8'h2C, 32'h1000_0000);

    // R11: flushes
    wr(8'h00, 32'h003F_0000);
    wr(8'h34, (32'd1 << 16) | 32'h1);
    wr(8'h34, (32'd1 << 27) | (32'd1 << 16) | 32'h2);
    wr(8'h00, 32'h003F_0C00);
    rd(8'h38, v); chk(v === 32'h0, "R11 receive flushed", v, 32'h0);
    wr(8'h00, 32'h803F_0000);
    repeat (300) @(negedge clk);
    chk(slv_got.size() == 9, "R11 transmit flushed", slv_got.size(), 9);
    rd(8'h00, v); chk(v === 32'h803F_0000, "R11 flush bits read 0", v, 32'h803F_0000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule